// File: doc/BRIEF.md
# Serial port interrupt, modem-control and loopback logic

This block is the interrupt and modem-control part of a byte-wide serial port of the classic PC style, with a reduced transmit path. Software reaches it through a register port: a 3-bit offset, single-cycle write and read strobes, and read data that is registered one cycle after the strobe. A byte written to the transmit holding register is moved into a shifter. After a fixed number of clock cycles per byte, which stands in for baud timing, it is finished. When loopback is selected, the finished byte lands in the receive buffer and raises data-ready.

Two interrupt sources exist: received data and transmit-holding-empty. Each has its own enable bit. The identification register reports the highest-priority enabled source as a code, and received data ranks above transmit-empty. The external interrupt line is a level. It is high while any enabled source is pending, the OUT2 control bit is set and loopback is off.

The modem-control register holds DTR, RTS, OUT1, OUT2 and a loopback bit. Outside loopback, each control bit drives a registered output pin. In loopback, all of these pins fall to their inactive level (0).

Top module: `uart_irq_loop`

## Requirements
- R1: After synchronous reset: IER reads 0x00, IIR reads 0x01, LSR reads 0x60, MCR reads 0x00, and all pin outputs and `irq_pin` are 0.
- R2: The IER (offset 1) keeps bits 1:0 and reads them back with bits 7:2 as zero. Bit 0 enables the received-data interrupt and bit 1 enables the transmit-holding-empty interrupt.
- R3: The IIR (offset 2) returns one of three codes:
  - 0x04 when received data is pending and enabled;
  - otherwise 0x02 when transmit-empty is pending and enabled;
  - otherwise 0x01, meaning nothing is pending.
- R4: The loopback delay works as follows:
  - With MCR bit 4 set, a byte written to offset 0 at clock edge E0 sets LSR bit 0 at edge E0+BYTE_CYCLES+1.
  - A read of offset 0 then returns that byte and clears LSR bit 0.
- R5: The transmit-empty condition follows these rules:
  - It is set at reset.
  - It is cleared by a write to offset 0.
  - It is cleared by a read of the IIR while the IIR shows 0x02.
  - It is set again when a byte moves from the holding register into the shifter, one edge after the write.
- R6: Writing 0 to the IER makes the IIR read 0x01 and drops `irq_pin`, whatever conditions are held.
- R7: `irq_pin` is a registered level. It equals (any enabled pending source) AND MCR bit 3 AND NOT MCR bit 4, one cycle late.
- R8: The MCR (offset 4) reads back bits 4:0: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback. The pins `pin_dtr`, `pin_rts`, `pin_out1` and `pin_out2` follow bits 0..3 one cycle late and are 0 while bit 4 is set.
- R9: With MCR bit 4 clear, a transmitted byte completes without setting LSR bit 0.
- R10: The LSR (offset 5) has two transmit status bits:
  - Bit 5 is 1 when the holding register is empty.
  - Bit 6 is 1 when both the holding register and the shifter are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered one cycle after `bus_rd` |
| irq_pin | output | 1 | Level interrupt request, gated by OUT2 |
| pin_dtr | output | 1 | DTR output, 0 in loopback |
| pin_rts | output | 1 | RTS output, 0 in loopback |
| pin_out1 | output | 1 | OUT1 output, 0 in loopback |
| pin_out2 | output | 1 | OUT2 output, 0 in loopback |

## Verification
The bench sweeps every combination of enable bits, OUT2, loopback, held received data and held transmit-empty. It checks the identification code, the interrupt pin and the control pins against values worked out from the rules. The sweep exposes the following faults:
- A priority inversion would show 0x02 while received data is enabled.
- A missing OUT2 or loopback gate would raise the pin wrongly.
- A design that dropped held state when the enables change would lose the condition.

Directed cases probe timing and the clear rules:
- The exact edge at which data-ready appears; an off-by-one shifter count shows there.
- The clear-on-read of a 0x02 identification, and the re-raise when the holding byte moves into the shifter.
- The non-loopback case, where a byte must never be received.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IIR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_MCR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSR  = 3'd5;

  localparam logic [DATA_W-1:0] IIR_NONE = 8'h01;
  localparam logic [DATA_W-1:0] IIR_TX   = 8'h02;
  localparam logic [DATA_W-1:0] IIR_RX   = 8'h04;

  localparam int MCR_BITS = 5;
  localparam int PIN_CNT  = 4;
  localparam int MCR_LOOP = 4;
  localparam int MCR_OUT2 = 3;
endpackage

// File: rtl/uart_tx_loop.sv
module uart_tx_loop #(
  parameter int DATA_W      = 8,
  parameter int BYTE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              loop_en,
  input  logic              rbr_rd,
  output logic              xfer,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_ready,
  output logic              hold_empty,
  output logic              all_empty
);
  localparam int CW = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(BYTE_CYCLES - 1);

  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic [DATA_W-1:0] shift_data;
  logic [CW-1:0]     cnt;
  logic              done;

  assign xfer = hold_valid && !busy;
  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else begin
      if (xfer) hold_valid <= 1'b0;
      if (thr_wr) begin
        hold_valid <= 1'b1;
        hold_data  <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      shift_data <= '0;
      cnt        <= '0;
    end else if (xfer) begin
      busy       <= 1'b1;
      shift_data <= hold_data;
      cnt        <= CNT_LOAD;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      data_ready <= 1'b0;
    end else if (done && loop_en) begin
      rx_data    <= shift_data;
      data_ready <= 1'b1;
    end else if (rbr_rd) begin
      data_ready <= 1'b0;
    end
  end

  assign hold_empty = !hold_valid;
  assign all_empty  = !hold_valid && !busy;

  assert_rbr_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rbr_rd && !done) |=> !data_ready);
  assert_no_rx_outside_loop_R9: assert property (@(posedge clk) disable iff (rst)
    (!loop_en && !data_ready) |=> !data_ready);
  assert_all_empty_implies_hold_R10: assert property (@(posedge clk) disable iff (rst)
    all_empty |-> hold_empty);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ier_wr,
  input  logic [1:0]        ier_wdata,
  input  logic              iir_rd,
  input  logic              thr_wr,
  input  logic              xfer,
  input  logic              data_ready,
  input  logic              mcr_out2,
  input  logic              mcr_loop,
  output logic [1:0]        ier,
  output logic [DATA_W-1:0] iir,
  output logic              irq_pin
);
  logic thre_flag;
  logic pend_rx;
  logic pend_tx;

  always_ff @(posedge clk) begin
    if (rst)         ier <= '0;
    else if (ier_wr) ier <= ier_wdata;
  end

  assign pend_rx = ier[0] && data_ready;
  assign pend_tx = ier[1] && thre_flag;

  always_comb begin
    if (pend_rx)      iir = IIR_RX;
    else if (pend_tx) iir = IIR_TX;
    else              iir = IIR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                               thre_flag <= 1'b1;
    else if (thr_wr)                       thre_flag <= 1'b0;
    else if (xfer)                         thre_flag <= 1'b1;
    else if (iir_rd && (iir == IIR_TX))    thre_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_pin <= 1'b0;
    else     irq_pin <= (pend_rx || pend_tx) && mcr_out2 && !mcr_loop;
  end

  assert_rx_priority_R3: assert property (@(posedge clk) disable iff (rst)
    (ier[0] && data_ready) |-> (iir == IIR_RX));
  assert_thre_raised_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer && !thr_wr) |=> thre_flag);
  assert_ier_zero_none_R6: assert property (@(posedge clk) disable iff (rst)
    (ier == 2'b00) |-> (iir == IIR_NONE));
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (!mcr_out2 || mcr_loop) |=> !irq_pin);
endmodule

// File: rtl/uart_mcr_pins.sv
module uart_mcr_pins
  import uart_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                mcr_wr,
  input  logic [MCR_BITS-1:0] mcr_wdata,
  output logic [MCR_BITS-1:0] mcr,
  output logic [PIN_CNT-1:0]  pins
);
  always_ff @(posedge clk) begin
    if (rst)         mcr <= '0;
    else if (mcr_wr) mcr <= mcr_wdata;
  end

  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pins[i] <= 1'b0;
      else     pins[i] <= mcr[i] && !mcr[MCR_LOOP];
    end
  end

  assert_loop_pins_idle_R8: assert property (@(posedge clk) disable iff (rst)
    mcr[MCR_LOOP] |=> (pins == '0));
endmodule

// File: rtl/uart_irq_loop.sv
module uart_irq_loop
  import uart_irq_pkg::*;
#(
  parameter int BYTE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pin,
  output logic              pin_dtr,
  output logic              pin_rts,
  output logic              pin_out1,
  output logic              pin_out2
);
  logic                thr_wr, ier_wr, mcr_wr, rbr_rd, iir_rd;
  logic                xfer, data_ready, hold_empty, all_empty;
  logic [DATA_W-1:0]   rx_data, iir;
  logic [1:0]          ier;
  logic [MCR_BITS-1:0] mcr;
  logic [PIN_CNT-1:0]  pins;
  logic [DATA_W-1:0]   lsr;
  logic [DATA_W-1:0]   rd_mux;

  assign thr_wr = bus_wr && (bus_addr == OFS_DATA);
  assign ier_wr = bus_wr && (bus_addr == OFS_IER);
  assign mcr_wr = bus_wr && (bus_addr == OFS_MCR);
  assign rbr_rd = bus_rd && (bus_addr == OFS_DATA);
  assign iir_rd = bus_rd && (bus_addr == OFS_IIR);

  uart_tx_loop #(.DATA_W(DATA_W), .BYTE_CYCLES(BYTE_CYCLES)) u_tx (
    .clk(clk), .rst(rst), .thr_wr(thr_wr), .wdata(bus_wdata),
    .loop_en(mcr[MCR_LOOP]), .rbr_rd(rbr_rd), .xfer(xfer),
    .rx_data(rx_data), .data_ready(data_ready),
    .hold_empty(hold_empty), .all_empty(all_empty)
  );

  uart_irq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(bus_wdata[1:0]),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .xfer(xfer), .data_ready(data_ready),
    .mcr_out2(mcr[MCR_OUT2]), .mcr_loop(mcr[MCR_LOOP]),
    .ier(ier), .iir(iir), .irq_pin(irq_pin)
  );

  uart_mcr_pins u_mcr (
    .clk(clk), .rst(rst), .mcr_wr(mcr_wr), .mcr_wdata(bus_wdata[MCR_BITS-1:0]),
    .mcr(mcr), .pins(pins)
  );

  assign pin_dtr  = pins[0];
  assign pin_rts  = pins[1];
  assign pin_out1 = pins[2];
  assign pin_out2 = pins[3];

  assign lsr = {1'b0, all_empty, hold_empty, 4'b0000, data_ready};

  always_comb begin
    case (bus_addr)
      OFS_DATA: rd_mux = rx_data;
      OFS_IER:  rd_mux = {6'b0, ier};
      OFS_IIR:  rd_mux = iir;
      OFS_MCR:  rd_mux = {{(DATA_W-MCR_BITS){1'b0}}, mcr};
      OFS_LSR:  rd_mux = lsr;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_irq_needs_out2_R7: assert property (@(posedge clk) disable iff (rst)
    irq_pin |-> $past(mcr[MCR_OUT2] && !mcr[MCR_LOOP]));
endmodule

// File: tb/uart_irq_loop_tb.sv
`timescale 1ns/1ps
module uart_irq_loop_tb;
  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_pin, pin_dtr, pin_rts, pin_out1, pin_out2;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  uart_irq_loop #(.BYTE_CYCLES(D)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin(irq_pin),
    .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_out1(pin_out1), .pin_out2(pin_out2)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: got 00 expected 01");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    rd(3'd1, rv); check("R1 ier", rv, 8'h00);
    rd(3'd2, rv); check("R1 iir", rv, 8'h01);
    rd(3'd5, rv); check("R1 lsr", rv, 8'h60);
    rd(3'd4, rv); check("R1 mcr", rv, 8'h00);
    check("R1 pins", {3'b0, irq_pin, pin_out2, pin_out1, pin_rts, pin_dtr}, 8'h00);

    // R2 IER readback sweep
    for (int v = 0; v < 256; v += 17) begin
      wr(3'd1, 8'(v)); rd(3'd1, rv);
      check("R2 ier readback", rv, 8'(v) & 8'h03);
    end

    // R8 MCR readback and pin following
    for (int v = 0; v < 32; v++) begin
      wr(3'd4, 8'(v)); @(negedge clk);
      rd(3'd4, rv); check("R8 mcr readback", rv, 8'(v));
      check("R8 pins", {4'b0, pin_out2, pin_out1, pin_rts, pin_dtr},
            (v & 16) ? 8'h00 : 8'(v & 15));
    end

    // R4 data-ready timing, RBR value and clear; R10 status bits
    do_reset();
    wr(3'd4, 8'h10);
    wr(3'd0, 8'hA5);            // write latched at E0
    rd(3'd5, rv); check("R10 lsr holding full", rv, 8'h00);
    rd(3'd5, rv); check("R10 lsr shifting", rv, 8'h20);
    repeat (D - 2) @(negedge clk);
    rd(3'd5, rv); check("R4 dr not early", rv & 8'h01, 8'h00);
    rd(3'd5, rv); check("R4 dr on time", rv, 8'h61);
    rd(3'd0, rv); check("R4 rbr value", rv, 8'hA5);
    rd(3'd5, rv); check("R4 dr cleared", rv & 8'h01, 8'h00);

    // R5 THR write clears transmit-empty, transfer re-raises, IIR read clears
    do_reset();
    wr(3'd1, 8'h02);
    rd(3'd2, rv); check("R5 iir tx after reset", rv, 8'h02);
    rd(3'd2, rv); check("R5 iir read cleared", rv, 8'h01);
    wr(3'd0, 8'h3C);
    rd(3'd2, rv); check("R5 write clears", rv, 8'h01);
    rd(3'd2, rv); check("R5 reraised on transfer", rv, 8'h02);
    rd(3'd2, rv); check("R5 cleared again", rv, 8'h01);

    // R9 no reception outside loopback
    do_reset();
    wr(3'd4, 8'h08);
    wr(3'd0, 8'h5A);
    repeat (D + 6) @(negedge clk);
    rd(3'd5, rv); check("R9 no dr, idle", rv, 8'h60);

    // R3 R6 R7 sweep over enables, OUT2, loopback, held rx and held tx-empty
    for (int c = 0; c < 64; c++) begin
      logic [1:0] ie; logic o2, lp, dr, te, ctl;
      logic [7:0] mcrv, exp_iir;
      ie = 2'(c & 3); o2 = c[2]; lp = c[3]; dr = c[4]; te = c[5]; ctl = c[0];
      do_reset();
      wr(3'd4, 8'h10);
      if (dr) begin
        wr(3'd0, 8'(c));
        repeat (D + 4) @(negedge clk);
      end
      if (!te) begin
        wr(3'd1, 8'h02);
        rd(3'd2, rv);
      end
      wr(3'd1, {6'b0, ie});
      mcrv = {3'b0, lp, o2, ctl, 1'b1, ~ctl};
      wr(3'd4, mcrv);
      repeat (2) @(negedge clk);
      exp_iir = (ie[0] && dr) ? 8'h04 : (ie[1] && te) ? 8'h02 : 8'h01;
      check(ie == 2'b00 ? "R6 irq off" : "R7 irq level", {7'b0, irq_pin},
            {7'b0, (exp_iir != 8'h01) && o2 && !lp});
      check("R8 pins sweep", {4'b0, pin_out2, pin_out1, pin_rts, pin_dtr},
            lp ? 8'h00 : mcrv & 8'h0F);
      rd(3'd5, rv); check("R4 dr held", rv & 8'h01, {7'b0, dr});
      rd(3'd2, rv); check(ie == 2'b00 ? "R6 iir none" : "R3 iir code", rv, exp_iir);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule